// File: doc/BRIEF.md
# Register Pair File with Role Exchange

This block holds the six 16-bit register pairs of a small 8-bit processor core: program counter, stack pointer, a hidden scratch pair used for instruction operands, the BC pair, and two interchangeable physical pairs. At any time one of the two interchangeable pairs plays the DE role and the other plays the HL role. A single flip-flop records which is which. An exchange command toggles that flip-flop, so DE and HL trade roles in one clock without any data being moved.

The block has two ports into the storage. The byte port takes the 3-bit register code from the instruction and reaches one byte: the upper two bits pick the pair and the low bit picks the high or low byte. The pair port takes a 3-bit pair code and reads or writes a whole 16-bit pair. Its lower two bits follow the instruction's pair field, and two further codes reach the program counter and the hidden pair. Reads are combinational. Writes land on the rising clock edge. Every DE or HL access passes through the role flip-flop to find its physical pair.

Top module: `regpair_file`

## Requirements
- R1: While `rst` is high at a rising edge, every pair is cleared to 0 and the role flip-flop is cleared, so that the first interchangeable pair acts as DE and the second acts as HL.
- R2: Byte codes map as 000=B, 001=C, 010=D, 011=E, 100=H, 101=L. A code with bit 0 = 0 reaches the high byte (bits 15:8) of its pair, and bit 0 = 1 reaches the low byte. A byte write changes only that byte.
- R3: Byte codes 110 and 111 reach no storage. A read with either code returns 0, and a write with either code changes no pair.
- R4: Pair codes 000=BC, 001=DE, 010=HL and 011=SP read and write all 16 bits. The high byte of BC/DE/HL is the byte that byte codes 000/010/100 reach.
- R5: Pair code 100 reaches the program counter and 101 reaches the hidden pair. Codes 110 and 111 read as 0 and their writes are ignored.
- R6: An `xchg` pulse swaps what DE and HL read and write from the next cycle on. No stored data moves, BC/SP/PC/hidden are unaffected, and a second pulse restores the roles.
- R7: Any access in the same cycle as `xchg` uses the roles in force before the toggle, for both reads and writes.
- R8: A byte write and a pair write in the same cycle both take effect. When they target the same pair, the byte write's byte wins and the other byte comes from the pair write.
- R9: `byte_rdata` and `pair_rdata` follow the selected storage in the same cycle while their read enable is high, and are 0 while it is low.
- R10: Each port's decode selects at most one physical pair in any cycle, so concurrent byte and pair reads of different pairs return independent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xchg | input | 1 | Toggle the DE/HL role flip-flop |
| byte_code | input | 3 | Register code for the byte port |
| byte_rd_en | input | 1 | Byte read enable |
| byte_wr_en | input | 1 | Byte write enable |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data (0 when idle) |
| pair_code | input | 3 | Pair code for the 16-bit port |
| pair_rd_en | input | 1 | Pair read enable |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wdata | input | 16 | Pair write data |
| pair_rdata | output | 16 | Pair read data (0 when idle) |

## Verification
The exchange command and a DE or HL access can fall in the same cycle. The bench provokes this by raising `xchg` together with a 16-bit DE write and a DE read. It judges the read sampled before the edge against the old DE contents, and afterwards expects the written value to appear under HL. A second overlap puts a byte write and a pair write in one cycle, first on different pairs and then on the same pair. The expected result of the same-pair case is that the byte write's byte wins.

// File: rtl/regpair_pkg.sv
package regpair_pkg;

    localparam int NPAIR = 6;

    // physical slots
    localparam int PH_PC = 0;
    localparam int PH_SP = 1;
    localparam int PH_WZ = 2;
    localparam int PH_BC = 3;
    localparam int PH_X0 = 4;
    localparam int PH_X1 = 5;

    typedef enum logic [2:0] {
        LG_BC   = 3'd0,
        LG_DE   = 3'd1,
        LG_HL   = 3'd2,
        LG_SP   = 3'd3,
        LG_PC   = 3'd4,
        LG_WZ   = 3'd5,
        LG_NONE = 3'd6
    } logical_e;

    typedef struct packed {
        logic [NPAIR-1:0] en;
        logic             hi;
    } byte_sel_t;

    function automatic logical_e byte_code_to_log(input logic [2:0] code);
        case (code[2:1])
            2'b00:   return LG_BC;
            2'b01:   return LG_DE;
            2'b10:   return LG_HL;
            default: return LG_NONE;
        endcase
    endfunction

    function automatic logical_e pair_code_to_log(input logic [2:0] code);
        if (!code[2]) begin
            case (code[1:0])
                2'b00:   return LG_BC;
                2'b01:   return LG_DE;
                2'b10:   return LG_HL;
                default: return LG_SP;
            endcase
        end
        if (code[1:0] == 2'b00) return LG_PC;
        if (code[1:0] == 2'b01) return LG_WZ;
        return LG_NONE;
    endfunction

    function automatic logic [NPAIR-1:0] log_to_phys(input logical_e lg, input logic swap);
        logic [NPAIR-1:0] oh;
        oh = '0;
        case (lg)
            LG_PC:   oh[PH_PC] = 1'b1;
            LG_SP:   oh[PH_SP] = 1'b1;
            LG_WZ:   oh[PH_WZ] = 1'b1;
            LG_BC:   oh[PH_BC] = 1'b1;
            LG_DE:   oh[swap ? PH_X1 : PH_X0] = 1'b1;
            LG_HL:   oh[swap ? PH_X0 : PH_X1] = 1'b1;
            default: oh = '0;
        endcase
        return oh;
    endfunction

endpackage

// File: rtl/regpair_swap.sv
module regpair_swap (
    input  logic clk,
    input  logic rst,
    input  logic xchg,
    output logic swap
);
    always_ff @(posedge clk) begin
        if (rst)       swap <= 1'b0;
        else if (xchg) swap <= ~swap;
    end
endmodule

// File: rtl/regpair_decode.sv
module regpair_decode
    import regpair_pkg::*;
(
    input  logic             swap,
    input  logic [2:0]       byte_code,
    input  logic [2:0]       pair_code,
    output byte_sel_t        byte_sel,
    output logic [NPAIR-1:0] pair_en
);
    always_comb begin
        byte_sel.en = log_to_phys(byte_code_to_log(byte_code), swap);
        byte_sel.hi = ~byte_code[0];
        pair_en     = log_to_phys(pair_code_to_log(pair_code), swap);
    end
endmodule

// File: rtl/regpair_store.sv
module regpair_store
    import regpair_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  byte_sel_t               byte_sel,
    input  logic                    byte_rd_en,
    input  logic                    byte_wr_en,
    input  logic [DATA_W-1:0]       byte_wdata,
    output logic [DATA_W-1:0]       byte_rdata,
    input  logic [NPAIR-1:0]        pair_en,
    input  logic                    pair_rd_en,
    input  logic                    pair_wr_en,
    input  logic [PAIR_W-1:0]       pair_wdata,
    output logic [PAIR_W-1:0]       pair_rdata,
    output logic [NPAIR*PAIR_W-1:0] store_flat
);
    logic [PAIR_W-1:0] pairs [NPAIR];

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                pairs[i] <= '0;
            end else begin
                if (pair_wr_en && pair_en[i])
                    pairs[i] <= pair_wdata;
                if (byte_wr_en && byte_sel.en[i]) begin
                    if (byte_sel.hi) pairs[i][PAIR_W-1:DATA_W] <= byte_wdata;
                    else             pairs[i][DATA_W-1:0]      <= byte_wdata;
                end
            end
        end
        assign store_flat[i*PAIR_W +: PAIR_W] = pairs[i];
    end

    always_comb begin
        byte_rdata = '0;
        pair_rdata = '0;
        for (int i = 0; i < NPAIR; i++) begin
            if (byte_rd_en && byte_sel.en[i])
                byte_rdata |= byte_sel.hi ? pairs[i][PAIR_W-1:DATA_W]
                                          : pairs[i][DATA_W-1:0];
            if (pair_rd_en && pair_en[i])
                pair_rdata |= pairs[i];
        end
    end
endmodule

// File: rtl/regpair_file.sv
module regpair_file
    import regpair_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xchg,
    input  logic [2:0]        byte_code,
    input  logic              byte_rd_en,
    input  logic              byte_wr_en,
    input  logic [DATA_W-1:0] byte_wdata,
    output logic [DATA_W-1:0] byte_rdata,
    input  logic [2:0]        pair_code,
    input  logic              pair_rd_en,
    input  logic              pair_wr_en,
    input  logic [PAIR_W-1:0] pair_wdata,
    output logic [PAIR_W-1:0] pair_rdata
);
    logic                    swap;
    byte_sel_t               byte_sel;
    logic [NPAIR-1:0]        pair_en;
    logic [NPAIR*PAIR_W-1:0] store_flat;

    regpair_swap u_swap (
        .clk  (clk),
        .rst  (rst),
        .xchg (xchg),
        .swap (swap)
    );

    regpair_decode u_dec (
        .swap      (swap),
        .byte_code (byte_code),
        .pair_code (pair_code),
        .byte_sel  (byte_sel),
        .pair_en   (pair_en)
    );

    regpair_store #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .byte_sel   (byte_sel),
        .byte_rd_en (byte_rd_en),
        .byte_wr_en (byte_wr_en),
        .byte_wdata (byte_wdata),
        .byte_rdata (byte_rdata),
        .pair_en    (pair_en),
        .pair_rd_en (pair_rd_en),
        .pair_wr_en (pair_wr_en),
        .pair_wdata (pair_wdata),
        .pair_rdata (pair_rdata),
        .store_flat (store_flat)
    );
endmodule

// File: rtl/regpair_file_chk.sv
module regpair_file_chk
    import regpair_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAIR_W = 2 * DATA_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    xchg,
    input logic [2:0]              byte_code,
    input logic                    byte_rd_en,
    input logic                    byte_wr_en,
    input logic [DATA_W-1:0]       byte_rdata,
    input logic                    pair_wr_en,
    input logic                    swap,
    input byte_sel_t               byte_sel,
    input logic [NPAIR-1:0]        pair_en,
    input logic [NPAIR*PAIR_W-1:0] store_flat
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (store_flat == '0 && swap == 1'b0));

    a_r6_role_toggles: assert property (@(posedge clk) disable iff (rst)
        xchg |=> (swap != $past(swap)));

    a_r6_data_kept: assert property (@(posedge clk) disable iff (rst)
        (xchg && !byte_wr_en && !pair_wr_en) |=> $stable(store_flat));

    a_r3_no_write: assert property (@(posedge clk) disable iff (rst)
        (byte_wr_en && byte_code[2:1] == 2'b11 && !pair_wr_en) |=> $stable(store_flat));

    a_r3_no_read: assert property (@(posedge clk) disable iff (rst)
        (byte_code[2:1] == 2'b11) |-> (byte_rdata == '0));

    a_r9_byte_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !byte_rd_en |-> (byte_rdata == '0));

    a_r10_byte_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(byte_sel.en));

    a_r10_pair_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pair_en));
endmodule

bind regpair_file regpair_file_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xchg       (xchg),
    .byte_code  (byte_code),
    .byte_rd_en (byte_rd_en),
    .byte_wr_en (byte_wr_en),
    .byte_rdata (byte_rdata),
    .pair_wr_en (pair_wr_en),
    .swap       (swap),
    .byte_sel   (byte_sel),
    .pair_en    (pair_en),
    .store_flat (store_flat)
);

// File: tb/regpair_file_tb.sv
module regpair_file_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        xchg;
    logic [2:0]  byte_code;
    logic        byte_rd_en, byte_wr_en;
    logic [7:0]  byte_wdata, byte_rdata;
    logic [2:0]  pair_code;
    logic        pair_rd_en, pair_wr_en;
    logic [15:0] pair_wdata, pair_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    regpair_file u_dut (
        .clk(clk), .rst(rst), .xchg(xchg),
        .byte_code(byte_code), .byte_rd_en(byte_rd_en), .byte_wr_en(byte_wr_en),
        .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
        .pair_code(pair_code), .pair_rd_en(pair_rd_en), .pair_wr_en(pair_wr_en),
        .pair_wdata(pair_wdata), .pair_rdata(pair_rdata)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        xchg = 0; byte_rd_en = 0; byte_wr_en = 0; pair_rd_en = 0; pair_wr_en = 0;
        byte_code = 0; pair_code = 0; byte_wdata = 0; pair_wdata = 0;
    endtask

    // drive at negedge, commit at posedge, release at next negedge
    task automatic wr_byte(input logic [2:0] c, input logic [7:0] v);
        @(negedge clk); byte_code = c; byte_wdata = v; byte_wr_en = 1;
        @(negedge clk); idle();
    endtask

    task automatic wr_pair(input logic [2:0] c, input logic [15:0] v);
        @(negedge clk); pair_code = c; pair_wdata = v; pair_wr_en = 1;
        @(negedge clk); idle();
    endtask

    task automatic pulse_xchg();
        @(negedge clk); xchg = 1;
        @(negedge clk); idle();
    endtask

    task automatic rd_pair(input string tag, input logic [2:0] c, input logic [15:0] exp);
        @(negedge clk); pair_code = c; pair_rd_en = 1;
        #2 check(tag, pair_rdata, exp);
        idle();
    endtask

    task automatic rd_byte(input string tag, input logic [2:0] c, input logic [7:0] exp);
        @(negedge clk); byte_code = c; byte_rd_en = 1;
        #2 check(tag, {8'h00, byte_rdata}, {8'h00, exp});
        idle();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 6; i++) rd_pair("R1 pair after reset", 3'(i), 16'h0000);
        for (int i = 0; i < 6; i++) rd_byte("R1 byte after reset", 3'(i), 8'h00);
    endtask

    task automatic t_bytes();
        wr_byte(3'b000, 8'h12); wr_byte(3'b001, 8'h34);
        wr_byte(3'b010, 8'h56); wr_byte(3'b011, 8'h78);
        wr_byte(3'b100, 8'h9A); wr_byte(3'b101, 8'hBC);
        rd_pair("R2 R4 BC from bytes", 3'b000, 16'h1234);
        rd_pair("R2 R4 DE from bytes", 3'b001, 16'h5678);
        rd_pair("R2 R4 HL from bytes", 3'b010, 16'h9ABC);
        rd_byte("R2 read D", 3'b010, 8'h56);
        rd_byte("R2 read L", 3'b101, 8'hBC);
        wr_byte(3'b011, 8'hE1);
        rd_pair("R2 E write keeps D", 3'b001, 16'h56E1);
        wr_byte(3'b011, 8'h78);
    endtask

    task automatic t_ignored();
        wr_byte(3'b110, 8'hFF);
        wr_byte(3'b111, 8'hEE);
        rd_pair("R3 BC untouched", 3'b000, 16'h1234);
        rd_pair("R3 DE untouched", 3'b001, 16'h5678);
        rd_pair("R3 HL untouched", 3'b010, 16'h9ABC);
        rd_pair("R3 SP untouched", 3'b011, 16'h0000);
        rd_pair("R3 PC untouched", 3'b100, 16'h0000);
        rd_pair("R3 WZ untouched", 3'b101, 16'h0000);
        rd_byte("R3 read code 110", 3'b110, 8'h00);
        rd_byte("R3 read code 111", 3'b111, 8'h00);
    endtask

    task automatic t_pairs();
        wr_pair(3'b011, 16'hBEEF);
        wr_pair(3'b100, 16'h1000);
        wr_pair(3'b101, 16'h2222);
        wr_pair(3'b110, 16'hDEAD);
        wr_pair(3'b111, 16'hDEAD);
        rd_pair("R4 SP", 3'b011, 16'hBEEF);
        rd_pair("R5 PC", 3'b100, 16'h1000);
        rd_pair("R5 WZ", 3'b101, 16'h2222);
        rd_pair("R5 code 110 reads 0", 3'b110, 16'h0000);
        rd_pair("R5 code 111 reads 0", 3'b111, 16'h0000);
        rd_pair("R5 BC kept", 3'b000, 16'h1234);
        rd_pair("R5 DE kept", 3'b001, 16'h5678);
        rd_pair("R5 HL kept", 3'b010, 16'h9ABC);
        wr_pair(3'b010, 16'hC0DE);
        rd_byte("R4 H is high of HL", 3'b100, 8'hC0);
        rd_byte("R4 L is low of HL", 3'b101, 8'hDE);
        wr_pair(3'b010, 16'h9ABC);
    endtask

    task automatic t_xchg();
        pulse_xchg();
        rd_pair("R6 DE after xchg", 3'b001, 16'h9ABC);
        rd_pair("R6 HL after xchg", 3'b010, 16'h5678);
        rd_byte("R6 D after xchg", 3'b010, 8'h9A);
        rd_byte("R6 L after xchg", 3'b101, 8'h78);
        rd_pair("R6 BC unaffected", 3'b000, 16'h1234);
        rd_pair("R6 SP unaffected", 3'b011, 16'hBEEF);
        rd_pair("R6 PC unaffected", 3'b100, 16'h1000);
        rd_pair("R6 WZ unaffected", 3'b101, 16'h2222);
        pulse_xchg();
        rd_pair("R6 DE restored", 3'b001, 16'h5678);
        rd_pair("R6 HL restored", 3'b010, 16'h9ABC);
    endtask

    task automatic t_same_cycle_xchg();
        @(negedge clk);
        xchg = 1; pair_code = 3'b001; pair_wdata = 16'hAAAA; pair_wr_en = 1; pair_rd_en = 1;
        byte_code = 3'b100; byte_rd_en = 1;
        #2 check("R7 DE read in xchg cycle", pair_rdata, 16'h5678);
        check("R7 H read in xchg cycle", {8'h00, byte_rdata}, 16'h009A);
        @(negedge clk); idle();
        rd_pair("R7 write landed in old DE, now HL", 3'b010, 16'hAAAA);
        rd_pair("R7 new DE is old HL", 3'b001, 16'h9ABC);
        // roles now swapped: DE=9ABC, HL=AAAA
    endtask

    task automatic t_both_writes();
        @(negedge clk);
        byte_code = 3'b001; byte_wdata = 8'h55; byte_wr_en = 1;
        pair_code = 3'b011; pair_wdata = 16'h0102; pair_wr_en = 1;
        @(negedge clk); idle();
        rd_pair("R8 BC byte write", 3'b000, 16'h1255);
        rd_pair("R8 SP pair write", 3'b011, 16'h0102);
        @(negedge clk);
        byte_code = 3'b000; byte_wdata = 8'h77; byte_wr_en = 1;
        pair_code = 3'b000; pair_wdata = 16'hA0B0; pair_wr_en = 1;
        @(negedge clk); idle();
        rd_pair("R8 same pair byte wins", 3'b000, 16'h77B0);
    endtask

    task automatic t_read_enable();
        @(negedge clk);
        byte_code = 3'b000; pair_code = 3'b011;
        #2 check("R9 byte idle reads 0", {8'h00, byte_rdata}, 16'h0000);
        check("R9 pair idle reads 0", pair_rdata, 16'h0000);
        byte_rd_en = 1; pair_rd_en = 1;
        #2 check("R9 R10 byte concurrent", {8'h00, byte_rdata}, 16'h0077);
        check("R9 R10 pair concurrent", pair_rdata, 16'h0102);
        byte_code = 3'b011; pair_code = 3'b010;
        #2 check("R10 E with swapped roles", {8'h00, byte_rdata}, 16'h00BC);
        check("R10 HL with swapped roles", pair_rdata, 16'hAAAA);
        idle();
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_bytes();
        t_ignored();
        t_pairs();
        t_xchg();
        t_same_cycle_xchg();
        t_both_writes();
        t_read_enable();
        // reset again clears data and roles
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd_pair("R1 DE after second reset", 3'b001, 16'h0000);
        wr_pair(3'b001, 16'h4321);
        rd_byte("R1 roles reset, D", 3'b010, 8'h43);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(20 * 100000);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule